// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns a set of active-low external interrupt pins into request flags for an interrupt controller. Each pin is first passed through a synchroniser. A per-channel trigger-type bit then decides how the pin raises a request. With the bit cleared, the channel is level triggered and its flag simply mirrors a low pin. With the bit set, the channel is edge triggered: a high-to-low transition sets a sticky flag, and the flag stays set until the interrupt controller sends that channel's acknowledge strobe.

Software writes and reads the trigger-type bits through a one-word register port. The block also drives the synchronised pin level as an output, so a timer gating function can use it without adding a second synchroniser. Enabling, prioritising and vectoring interrupts are handled by the consuming logic, not by this block.

Top module: `extirq_latch`

## Requirements
- R1: After reset all type bits read 0 (level triggering), every request flag is 0 and every synchronised pin level is 1.
- R2: A cycle with `cfgWe` high loads `cfgWdata` into the type bits. `cfgRdata` shows the new value after that clock edge. Bit i is the type of channel i: 1 selects falling-edge triggering and 0 selects low-level triggering.
- R3: `pinLevel[i]` equals `pinN[i]` as it was sampled two clock edges earlier (a two-flop synchroniser).
- R4: When channel i is in level mode, `reqFlag[i]` equals the inverse of `pinLevel[i]` on every cycle.
- R5: When channel i is in edge mode, a falling edge is the synchronised level going from 1 to 0 between consecutive cycles. The edge sets `reqFlag[i]` one edge after it appears on `pinLevel[i]`, which is three clock edges after the pin falls.
- R6: When channel i is in edge mode, a set flag stays set while no acknowledge arrives, even after the pin returns high.
- R7: When channel i is in edge mode, `ackStrobe[i]` high at a clock edge clears `reqFlag[i]` at that edge, unless a new falling edge is detected at the same edge.
- R8: When channel i is in edge mode, if an acknowledge and a newly detected falling edge fall on the same clock edge, the flag stays set, so the new request is not lost.
- R9: When channel i is in level mode, `ackStrobe[i]` has no effect: the flag keeps following the pin.
- R10: The channels are independent. A pin, acknowledge or type change on one channel leaves the other channels' flags unchanged.
- R11: While a channel is in level mode, its edge latch is held clear. After a switch to edge mode the flag starts at 0 until a new falling edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pinN | input | NUM_CH | Active-low external interrupt pins, asynchronous |
| ackStrobe | input | NUM_CH | Per-channel acknowledge strobe from the interrupt controller |
| cfgWe | input | 1 | Write enable for the type register |
| cfgWdata | input | NUM_CH | New type bits (1 = falling edge, 0 = low level) |
| cfgRdata | output | NUM_CH | Current type bits |
| reqFlag | output | NUM_CH | Per-channel interrupt request flag |
| pinLevel | output | NUM_CH | Synchronised pin level for timer gating |

## Verification
A corrupted edge latch has two visible symptoms. A stale latch makes `reqFlag` rise on the very first cycle after a channel is switched to edge mode, with no pin activity. A latch that fails to hold drops the flag within one cycle of the pin going high. Synchroniser faults change the two-cycle latency seen on `pinLevel` and the three-cycle latency of an edge request, so the checks sample at those exact cycles. An acknowledge that is applied to the wrong channel, or in level mode, changes `reqFlag` on the next edge, and the neighbouring channel's flag is checked at that same edge.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic edgeMode;  // 1: falling-edge triggered, 0: low-level triggered
    logic setReq;    // set the edge latch this cycle
    logic clrReq;    // clear the edge latch this cycle (set wins)
  } chanCtl_t;

endpackage

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgWe,
  input  logic [NUM_CH-1:0]     cfgWdata,
  input  logic [NUM_CH-1:0]     ackStrobe,
  input  logic [NUM_CH-1:0]     fallDet,
  output logic [NUM_CH-1:0]     cfgRdata,
  output chanCtl_t [NUM_CH-1:0] ctl
);

  logic [NUM_CH-1:0] typeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typeQ <= '0;
    end else if (cfgWe) begin
      typeQ <= cfgWdata;
    end
  end

  assign cfgRdata = typeQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ctl
    // A new edge takes precedence over acknowledge; level mode keeps the latch cleared
    assign ctl[i].edgeMode = typeQ[i];
    assign ctl[i].setReq   = typeQ[i] & fallDet[i];
    assign ctl[i].clrReq   = ~typeQ[i] | ackStrobe[i];
  end

endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     pinN,
  input  chanCtl_t [NUM_CH-1:0] ctl,
  output logic [NUM_CH-1:0]     fallDet,
  output logic [NUM_CH-1:0]     pinLevel,
  output logic [NUM_CH-1:0]     reqFlag
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic [SYNC_STAGES-1:0] shiftQ;
    logic                   prevQ;
    logic                   edgeFlagQ;
    logic                   syncCur;

    assign syncCur = shiftQ[LAST];

    // Synchroniser and previous-sample register; idle level of the pin is high
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shiftQ <= '1;
        prevQ  <= 1'b1;
      end else begin
        shiftQ <= {shiftQ[SYNC_STAGES-2:0], pinN[i]};
        prevQ  <= syncCur;
      end
    end

    // Sticky edge latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        edgeFlagQ <= 1'b0;
      end else if (ctl[i].setReq) begin
        edgeFlagQ <= 1'b1;
      end else if (ctl[i].clrReq) begin
        edgeFlagQ <= 1'b0;
      end
    end

    assign fallDet[i]  = prevQ & ~syncCur;
    assign pinLevel[i] = syncCur;
    assign reqFlag[i]  = ctl[i].edgeMode ? edgeFlagQ : ~syncCur;

    assert_edge_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i].edgeMode && prevQ && !syncCur) |=> edgeFlagQ)
      else $error("edge not latched on channel %0d", i);

    assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i].edgeMode && edgeFlagQ && !ctl[i].clrReq) |=> edgeFlagQ)
      else $error("edge latch dropped without acknowledge on channel %0d", i);

    assert_ack_race_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i].edgeMode && ctl[i].clrReq && prevQ && !syncCur) |=> edgeFlagQ)
      else $error("new edge lost to acknowledge on channel %0d", i);

    assert_level_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl[i].edgeMode |=> !edgeFlagQ)
      else $error("edge latch not held clear in level mode on channel %0d", i);
  end

endmodule

// File: rtl/extirq_latch.sv
module extirq_latch
  import extirq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pinN,
  input  logic [NUM_CH-1:0] ackStrobe,
  input  logic              cfgWe,
  input  logic [NUM_CH-1:0] cfgWdata,
  output logic [NUM_CH-1:0] cfgRdata,
  output logic [NUM_CH-1:0] reqFlag,
  output logic [NUM_CH-1:0] pinLevel
);

  chanCtl_t [NUM_CH-1:0] ctl;
  logic [NUM_CH-1:0]     fallDet;

  extirq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWe     (cfgWe),
    .cfgWdata  (cfgWdata),
    .ackStrobe (ackStrobe),
    .fallDet   (fallDet),
    .cfgRdata  (cfgRdata),
    .ctl       (ctl)
  );

  extirq_datapath #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinN     (pinN),
    .ctl      (ctl),
    .fallDet  (fallDet),
    .pinLevel (pinLevel),
    .reqFlag  (reqFlag)
  );

endmodule

// File: tb/extirq_latch_tb.sv
`timescale 1ns/1ps
module extirq_latch_tb;

  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pinN = '1;
  logic [NCH-1:0] ackStrobe = '0;
  logic           cfgWe = 1'b0;
  logic [NCH-1:0] cfgWdata = '0;
  logic [NCH-1:0] cfgRdata, reqFlag, pinLevel;

  extirq_latch #(.NUM_CH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .pinN(pinN), .ackStrobe(ackStrobe),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqFlag(reqFlag), .pinLevel(pinLevel)
  );

  always #4 clk = ~clk;  // 125 MHz

  // kinds: 0 reqFlag, 1 pinLevel, 2 cfgRdata
  typedef struct {
    int             due;
    int             kind;
    logic [NCH-1:0] exp;
    string          tag;
  } item_t;

  item_t expQ[$];
  int    cycle = 0;
  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cycle <= cycle + 1;

  // Monitor: compare scoreboard items at their due cycle, away from the edge
  always @(posedge clk) begin
    #2;
    while (expQ.size() > 0 && expQ[0].due <= cycle) begin
      item_t it;
      logic [NCH-1:0] act;
      it = expQ.pop_front();
      case (it.kind)
        0: act = reqFlag;
        1: act = pinLevel;
        default: act = cfgRdata;
      endcase
      nChecks++;
      if (act !== it.exp || it.due != cycle) begin
        nFail++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%b expected=%b",
                 it.tag, it.kind, cycle, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(int d, int kind, logic [NCH-1:0] e, string tag);
    item_t it;
    it.due = cycle + d; it.kind = kind; it.exp = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic writeType(logic [NCH-1:0] v);
    cfgWe = 1'b1; cfgWdata = v;
    step(1);
    cfgWe = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() > 0) step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1: reset state
    push(1, 0, 2'b00, "R1");
    push(1, 1, 2'b11, "R1");
    push(1, 2, 2'b00, "R1");
    step(2);

    // R2: type register write and readback
    cfgWe = 1'b1; cfgWdata = 2'b10;
    push(1, 2, 2'b10, "R2");
    step(1);
    cfgWdata = 2'b01;
    push(1, 2, 2'b01, "R2");
    step(1);
    cfgWdata = 2'b00;
    push(1, 2, 2'b00, "R2");
    step(1);
    cfgWe = 1'b0;
    step(2);

    // R3/R4: level mode, channel 0 low
    pinN = 2'b10;
    push(1, 1, 2'b11, "R3");
    push(2, 1, 2'b10, "R3");
    push(2, 0, 2'b01, "R4");
    step(4);
    // R9: acknowledge in level mode is ignored
    ackStrobe = 2'b01;
    step(1);
    ackStrobe = 2'b00;
    push(1, 0, 2'b01, "R9");
    step(2);
    pinN = 2'b11;
    push(2, 0, 2'b00, "R4");
    push(2, 1, 2'b11, "R3");
    step(4);

    // Edge mode on both channels
    writeType(2'b11);
    push(1, 0, 2'b00, "R11");
    step(2);
    // R5: fall on channel 0
    pinN = 2'b10;
    push(2, 0, 2'b00, "R5");
    push(3, 0, 2'b01, "R5");
    step(4);
    // R6: pin returns high, flag holds
    pinN = 2'b11;
    push(5, 0, 2'b01, "R6");
    step(6);
    // R7: acknowledge clears
    ackStrobe = 2'b01;
    step(1);
    ackStrobe = 2'b00;
    push(1, 0, 2'b00, "R7");
    step(2);

    // R10: channel 1 edge leaves channel 0 alone
    pinN = 2'b01;
    push(3, 0, 2'b10, "R10");
    step(4);
    pinN = 2'b11;
    step(3);
    // R8: new edge on channel 1 coincides with its acknowledge
    pinN = 2'b01;
    step(2);
    ackStrobe = 2'b10;
    push(1, 0, 2'b10, "R8");
    step(1);
    ackStrobe = 2'b00;
    push(1, 0, 2'b10, "R8");
    step(2);
    // R7/R10: acknowledge channel 1 only
    pinN = 2'b11;
    step(3);
    ackStrobe = 2'b10;
    step(1);
    ackStrobe = 2'b00;
    push(1, 0, 2'b00, "R7");
    step(2);

    // Both channels fall together
    pinN = 2'b00;
    push(3, 0, 2'b11, "R5");
    step(4);
    pinN = 2'b11;
    step(3);

    // R11: back to level then edge, latch must start clear
    writeType(2'b00);
    push(1, 0, 2'b00, "R11");
    step(2);
    writeType(2'b11);
    push(1, 0, 2'b00, "R11");
    push(3, 0, 2'b00, "R11");
    step(4);

    // R10: type change on channel 1 only, channel 0 edge flag set first
    pinN = 2'b10;
    step(4);
    pinN = 2'b00;
    writeType(2'b01);
    push(2, 0, 2'b11, "R10");
    step(4);
    pinN = 2'b11;
    push(3, 0, 2'b01, "R10");
    step(4);

    drain();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule